// File: doc/BRIEF.md
# Byte-Mode I2C Target Controller

This block is an I2C target that moves one byte at a time and hands every byte to a host through a small word-addressed register port. It recognises a programmable 7-bit address. Once that address is matched it acknowledges every byte the bus controller writes. On a read it shifts out bytes that software supplies through the same data register that holds received bytes.

After the address byte and after each data byte, the block raises an interrupt flag and holds SCL low. It keeps SCL low until software clears the flag by writing a 1 to it. On a read, software must also have written the next byte before SCL is let go. A STOP marks the end of the transaction, and a repeated START that turns a write into a read is flagged in a separate global status bit.

Software-written configuration is staged in shadow registers. It reaches the bus logic only when software sets a load-request bit, and that bit clears itself once the copy is done. SDA and SCL are open-drain: each output port, when high, pulls its line low.

Top module: `i2c_byte_target`

## Requirements
- R1: After reset every register reads zero, neither bus line is pulled low and `irq` is low.
- R2: Writes to the control (word 0), own-address (word 1) and mode (word 2) registers read back at once but do not change bus behaviour until bit 1 of the load register (word 7) is written as 1. That bit reads 1 in the cycle after the write and 0 in the cycle after that.
- R3: The target acknowledges an address byte only when its upper seven bits equal bits 6:0 of the active own address and the active 17-bit mode field is zero. A match sets status bit 3 (interrupt) and bit 2 (address received), and status bit 1 takes the address byte's R/W bit. A mismatch is not acknowledged and sets no flag.
- R4: From the fall of the ninth clock of an acknowledged address or data byte, SCL is held low. It stays low until status bit 3 is clear and, when bit 1 says read, until a transmit byte has also been written to the data register (word 4).
- R5: On a host write, each data byte is acknowledged, is readable from bits 7:0 of the data register, and sets status bit 3.
- R6: On a host read, the byte written to the data register is sent MSB first. A host ACK sets status bit 3 and stretches SCL. A host NACK sets no flag, releases both lines and leaves the target idle until STOP or START.
- R7: A STOP after an addressed transfer sets status bit 4 (end of transaction) and status bit 3.
- R8: Status bits 4..1 (word 3) clear only where a 1 is written; bits written as 0 keep their value.
- R9: `irq` is high exactly when some status bit among 4, 3 and 2 is set and the same bit is set in the mask register (word 5).
- R10: A repeated START after an addressed write, followed by a matched read address, sets bit 26 of the global status register (word 6). A plain read does not set it, and writing 1 to bit 26 clears it.
- R11: Unless both the enable bit (control bit 3) and the new-target bit (control bit 2) are active, the target never drives either line and acknowledges nothing.
- R12: If a STOP flag is still pending when a new address match occurs, status bits 4, 3 and 2 are all seen set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Register word offset |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Register read data (combinational) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong bit counter or state in the byte engine shows up within one byte time. The ACK arrives on the wrong clock, which corrupts the byte the bus controller reads back, or SCL is stretched at the wrong point and the bus controller sees its clock stall or run on. Bad flag bookkeeping shows in the status word read right after the ninth clock falls, or in `irq` in the same cycle. A stretch that never lets go stalls the bus controller's next clock rise, and the bench catches this through a bounded wait. Stale or early configuration shows as an ACK, or a missing ACK, on the very next address byte.

// File: rtl/i2c_byte_target.sv
module i2c_byte_target #(
  parameter int AW        = 3,
  parameter int DW        = 32,
  parameter int OWN_W     = 7,
  parameter int MODE_W    = 17,
  parameter int TURN_BIT  = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_OWN  = AW'(1);
  localparam logic [AW-1:0] A_MODE = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_DATA = AW'(4);
  localparam logic [AW-1:0] A_MASK = AW'(5);
  localparam logic [AW-1:0] A_TURN = AW'(6);
  localparam logic [AW-1:0] A_LOAD = AW'(7);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_STR, S_TX, S_TACK, S_WAIT} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       start_ev, stop_ev, rise, fall;

  logic             en_sh, new_sh, en_act, new_act, act_on, load_q;
  logic [OWN_W-1:0] own_sh, own_act;
  logic [MODE_W-1:0] mode_sh, mode_act;

  logic       st_end, st_irq, st_adr, st_rnw, turn_q, tx_pend;
  logic [2:0] mask_q;
  logic [7:0] data_q, sh, shtx;
  logic [3:0] cnt;
  st_t        state;
  logic       is_addr, addressed, rnw_q, ack_q, wr_rs, sda_drv, scl_drv;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[DW-1:TURN_BIT+1], reg_wdata[TURN_BIT-1:MODE_W]};

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise     = scl_s & ~scl_q;
  assign fall     = ~scl_s & scl_q;
  assign act_on   = en_act & new_act;
  assign scl_oe   = scl_drv;
  assign sda_oe   = sda_drv;
  assign irq      = |({st_end, st_irq, st_adr} & mask_q);

  function automatic logic wr(input logic [AW-1:0] a);
    return reg_we && (reg_addr == a);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_sh <= 1'b0; new_sh <= 1'b0; own_sh <= '0; mode_sh <= '0;
      en_act <= 1'b0; new_act <= 1'b0; own_act <= '0; mode_act <= '0;
      load_q <= 1'b0; mask_q <= '0;
    end else begin
      if (wr(A_CTRL)) begin en_sh <= reg_wdata[3]; new_sh <= reg_wdata[2]; end
      if (wr(A_OWN))  own_sh  <= reg_wdata[OWN_W-1:0];
      if (wr(A_MODE)) mode_sh <= reg_wdata[MODE_W-1:0];
      if (wr(A_MASK)) mask_q  <= reg_wdata[4:2];
      if (load_q) begin
        en_act <= en_sh; new_act <= new_sh; own_act <= own_sh; mode_act <= mode_sh;
        load_q <= 1'b0;
      end
      if (wr(A_LOAD) && reg_wdata[1]) load_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_end <= 1'b0; st_irq <= 1'b0; st_adr <= 1'b0; st_rnw <= 1'b0;
      turn_q <= 1'b0; tx_pend <= 1'b0; data_q <= '0; sh <= '0; shtx <= '0;
      cnt <= '0; state <= S_IDLE; is_addr <= 1'b0; addressed <= 1'b0;
      rnw_q <= 1'b0; ack_q <= 1'b0; wr_rs <= 1'b0; sda_drv <= 1'b0; scl_drv <= 1'b0;
    end else begin
      if (wr(A_STAT)) begin
        if (reg_wdata[4]) st_end <= 1'b0;
        if (reg_wdata[3]) st_irq <= 1'b0;
        if (reg_wdata[2]) st_adr <= 1'b0;
        if (reg_wdata[1]) st_rnw <= 1'b0;
      end
      if (wr(A_TURN) && reg_wdata[TURN_BIT]) turn_q <= 1'b0;
      if (wr(A_DATA)) begin data_q <= reg_wdata[7:0]; tx_pend <= 1'b1; end

      if (!act_on) begin
        state <= S_IDLE; sda_drv <= 1'b0; scl_drv <= 1'b0;
        addressed <= 1'b0; wr_rs <= 1'b0;
      end else if (start_ev) begin
        wr_rs <= addressed & ~rnw_q;
        state <= S_RX; is_addr <= 1'b1; cnt <= '0;
        sda_drv <= 1'b0; scl_drv <= 1'b0;
      end else if (stop_ev) begin
        if (addressed) begin st_end <= 1'b1; st_irq <= 1'b1; end
        addressed <= 1'b0; wr_rs <= 1'b0; state <= S_IDLE;
        sda_drv <= 1'b0; scl_drv <= 1'b0;
      end else begin
        case (state)
          S_RX:
            if (rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              if (is_addr) begin
                if (sh[7:1] == own_act && mode_act == '0) begin
                  addressed <= 1'b1; rnw_q <= sh[0]; sda_drv <= 1'b1; state <= S_RACK;
                end else begin
                  addressed <= 1'b0; state <= S_WAIT;
                end
              end else begin
                data_q <= sh; sda_drv <= 1'b1; state <= S_RACK;
              end
            end
          S_RACK:
            if (fall) begin
              sda_drv <= 1'b0; st_irq <= 1'b1; scl_drv <= 1'b1; state <= S_STR;
              if (is_addr) begin
                st_adr <= 1'b1; st_rnw <= rnw_q; wr_rs <= 1'b0;
                if (rnw_q && wr_rs) turn_q <= 1'b1;
              end
            end
          S_STR:
            if (!st_irq && (!rnw_q || tx_pend)) begin
              scl_drv <= 1'b0; cnt <= '0;
              if (rnw_q) begin
                shtx <= data_q; sda_drv <= ~data_q[7]; tx_pend <= 1'b0; state <= S_TX;
              end else begin
                is_addr <= 1'b0; state <= S_RX;
              end
            end
          S_TX:
            if (fall) begin
              if (cnt == 4'd7) begin
                sda_drv <= 1'b0; state <= S_TACK;
              end else begin
                cnt <= cnt + 4'd1; sda_drv <= ~shtx[6]; shtx <= {shtx[6:0], 1'b0};
              end
            end
          S_TACK:
            if (rise) ack_q <= ~sda_s;
            else if (fall) begin
              if (ack_q) begin st_irq <= 1'b1; scl_drv <= 1'b1; state <= S_STR; end
              else state <= S_WAIT;
            end
          default: ;
        endcase
      end
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin reg_rdata[3] = en_sh; reg_rdata[2] = new_sh; end
      A_OWN:  reg_rdata[OWN_W-1:0]  = own_sh;
      A_MODE: reg_rdata[MODE_W-1:0] = mode_sh;
      A_STAT: reg_rdata[4:1] = {st_end, st_irq, st_adr, st_rnw};
      A_DATA: reg_rdata[7:0] = data_q;
      A_MASK: reg_rdata[4:2] = mask_q;
      A_TURN: reg_rdata[TURN_BIT] = turn_q;
      A_LOAD: reg_rdata[1] = load_q;
      default: ;
    endcase
  end

  p_load_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && !(reg_we && reg_addr == A_LOAD)) |=> !load_q);

  p_match_has_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_adr) |-> st_irq);

  p_stretch_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !st_irq && (!rnw_q || tx_pend)) |=> !scl_oe);

  p_sda_moves_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_on && $past(act_on) && (sda_oe != $past(sda_oe))) |-> !scl_s);

  p_end_has_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_end) |-> st_irq);

  p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !act_on |=> (!sda_oe && !scl_oe));
endmodule

// File: tb/i2c_byte_target_bench.sv
module i2c_byte_target_bench;
  localparam int HP = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic m_scl = 1'b0, m_sda = 1'b0;
  logic scl_bus, sda_bus;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic ack, s;
  logic [7:0] rb;
  logic [31:0] rv;
  logic [6:0] ta;
  logic [7:0] td;
  logic te;

  // {address7, data8, expect_ack}
  localparam logic [15:0] VEC [0:5] = '{
    {7'h3A, 8'h5C, 1'b1}, {7'h3A, 8'h00, 1'b1}, {7'h3A, 8'hFF, 1'b1},
    {7'h3B, 8'h11, 1'b0}, {7'h1A, 8'h22, 1'b0}, {7'h3A, 8'hA5, 1'b1}};

  assign scl_bus = ~(m_scl | scl_oe);
  assign sda_bus = ~(m_sda | sda_oe);

  always #5 clk = ~clk;

  i2c_byte_target u_i2c_byte_target (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic hp(); repeat (HP) @(negedge clk); endtask

  task automatic scl_up();
    int t = 0;
    m_scl = 1'b0;
    while (scl_bus !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
    if (t >= 4000) chk("R4 stretch never released", 32'(scl_bus), 32'd1);
  endtask

  task automatic bitx(input logic b, output logic smp);
    m_sda = ~b; hp(); scl_up(); hp(); smp = sda_bus; m_scl = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic start_c(); m_sda = 1'b1; hp(); m_scl = 1'b1; repeat (4) @(negedge clk); endtask
  task automatic rstart_c();
    m_sda = 1'b0; hp(); scl_up(); hp(); m_sda = 1'b1; hp(); m_scl = 1'b1; repeat (4) @(negedge clk);
  endtask
  task automatic stop_c(); m_sda = 1'b1; hp(); scl_up(); hp(); m_sda = 1'b0; hp(); endtask

  task automatic send(input logic [7:0] b, output logic a);
    logic x;
    for (int i = 7; i >= 0; i--) bitx(b[i], x);
    bitx(1'b1, x);
    a = ~x;
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin bitx(1'b1, x); b[i] = x; end
    bitx(~give_ack, x);
  endtask

  task automatic cfg(input logic [31:0] ctrl, input logic [31:0] own, input logic [31:0] mode);
    wr(0, ctrl); wr(1, own); wr(2, mode); wr(7, 32'h2); repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), rv); chk("R1 reg reset", rv, 0); end
    chk("R1 scl_oe", 32'(scl_oe), 0); chk("R1 sda_oe", 32'(sda_oe), 0); chk("R1 irq", 32'(irq), 0);

    // R2 staged config not yet active
    wr(0, 32'hC); wr(1, 32'h3A);
    rd(0, rv); chk("R2 ctrl readback", rv, 32'hC);
    start_c(); send({7'h3A, 1'b0}, ack); chk("R2 no ack before load", 32'(ack), 0); stop_c();
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'd7; reg_wdata = 32'h2;
    @(negedge clk); reg_we = 1'b0; #1 chk("R2 load bit set", reg_rdata, 32'h2);
    @(negedge clk); #1 chk("R2 load bit self-clear", reg_rdata, 32'h0);
    repeat (3) @(negedge clk);

    // vector table: host writes (R3 R4 R5 R7)
    for (int i = 0; i < 6; i++) begin
      ta = VEC[i][15:9]; td = VEC[i][8:1]; te = VEC[i][0];
      start_c(); send({ta, 1'b0}, ack);
      chk("R3 address ack", 32'(ack), 32'(te));
      repeat (10) @(negedge clk); rd(3, rv);
      if (te) begin
        chk("R3 match flags", rv, 32'hC);
        chk("R4 held after address", 32'(scl_oe), 1);
        repeat (100) @(negedge clk);
        chk("R4 still held", 32'(scl_oe), 1);
        wr(3, 32'hC);
        send(td, ack); chk("R5 data ack", 32'(ack), 1);
        repeat (10) @(negedge clk);
        rd(3, rv); chk("R5 data flag", rv, 32'h8);
        rd(4, rv); chk("R5 data value", rv, 32'(td));
        chk("R4 held after data", 32'(scl_oe), 1);
        wr(3, 32'h8);
      end else begin
        chk("R3 no flags", rv, 0);
        chk("R3 no drive", 32'(sda_oe), 0);
      end
      stop_c(); repeat (10) @(negedge clk);
      rd(3, rv); chk("R7 stop flags", rv, te ? 32'h18 : 32'h0);
      wr(3, 32'h18);
    end

    // R8 R9 partial clear and masking
    start_c(); send({7'h3A, 1'b0}, ack); repeat (10) @(negedge clk);
    chk("R9 masked off", 32'(irq), 0);
    wr(5, 32'h4); chk("R9 addr source", 32'(irq), 1);
    wr(3, 32'h4); rd(3, rv); chk("R8 partial clear", rv, 32'h8);
    chk("R9 source gone", 32'(irq), 0);
    chk("R4 held while bit3 set", 32'(scl_oe), 1);
    wr(5, 32'h8); chk("R9 irq source", 32'(irq), 1);
    wr(5, 32'h0); wr(3, 32'h8);
    send(8'h81, ack); repeat (10) @(negedge clk); wr(3, 32'h8);
    stop_c(); repeat (10) @(negedge clk);
    // R12 end still pending when next match occurs
    start_c(); send({7'h3A, 1'b0}, ack); repeat (10) @(negedge clk);
    rd(3, rv); chk("R12 end and match together", rv, 32'h1C);
    wr(3, 32'h1C); stop_c(); repeat (10) @(negedge clk); wr(3, 32'h18);

    // R6 host read
    start_c(); send({7'h3A, 1'b1}, ack); chk("R6 read address ack", 32'(ack), 1);
    repeat (10) @(negedge clk); rd(3, rv); chk("R3 read direction", rv, 32'hE);
    wr(3, 32'hC); repeat (20) @(negedge clk);
    chk("R4 held until tx byte", 32'(scl_oe), 1);
    wr(4, 32'hC3); recv(1'b1, rb); chk("R6 first byte", 32'(rb), 32'hC3);
    repeat (10) @(negedge clk); rd(3, rv); chk("R6 ack flag", rv, 32'hA);
    chk("R6 stretch after ack", 32'(scl_oe), 1);
    wr(3, 32'h8); wr(4, 32'h96); recv(1'b0, rb); chk("R6 second byte", 32'(rb), 32'h96);
    repeat (10) @(negedge clk); rd(3, rv); chk("R6 nack no flag", rv, 32'h2);
    chk("R6 nack scl free", 32'(scl_oe), 0); chk("R6 nack sda free", 32'(sda_oe), 0);
    stop_c(); repeat (10) @(negedge clk);
    rd(3, rv); chk("R7 stop after read", rv, 32'h1A); wr(3, 32'h1A);
    rd(6, rv); chk("R10 plain read no turn", rv, 0);

    // R10 write then repeated START read
    start_c(); send({7'h3A, 1'b0}, ack); repeat (10) @(negedge clk); wr(3, 32'hC);
    send(8'h44, ack); repeat (10) @(negedge clk); wr(3, 32'h8);
    rstart_c(); send({7'h3A, 1'b1}, ack); chk("R10 read ack", 32'(ack), 1);
    repeat (10) @(negedge clk);
    rd(6, rv); chk("R10 turn flag", rv, 32'h0400_0000);
    rd(3, rv); chk("R10 status", rv, 32'hE);
    wr(6, 32'h0400_0000); rd(6, rv); chk("R10 turn cleared", rv, 0);
    wr(3, 32'hC); wr(4, 32'h5A); recv(1'b0, rb); chk("R10 byte", 32'(rb), 32'h5A);
    stop_c(); repeat (10) @(negedge clk); wr(3, 32'h1E);

    // R3 nonzero mode field
    cfg(32'hC, 32'h3A, 32'h1);
    start_c(); send({7'h3A, 1'b0}, ack); chk("R3 mode nonzero no ack", 32'(ack), 0);
    stop_c(); repeat (10) @(negedge clk); rd(3, rv); chk("R3 mode no flags", rv, 0);

    // R11 disable variants
    cfg(32'h8, 32'h3A, 32'h0);
    start_c(); send({7'h3A, 1'b0}, ack); chk("R11 new bit clear no ack", 32'(ack), 0);
    chk("R11 no scl drive", 32'(scl_oe), 0); stop_c();
    cfg(32'h0, 32'h3A, 32'h0);
    start_c(); send({7'h3A, 1'b0}, ack); chk("R11 disabled no ack", 32'(ack), 0);
    stop_c(); repeat (10) @(negedge clk); rd(3, rv); chk("R11 no flags", rv, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule